// File: doc/BRIEF.md
# Multi-channel DAC SPI command engine

This block turns single-cycle host commands into serial command frames for a multi-channel digital-to-analog converter. The host supplies an operation code, a channel number and a 16-bit value. The block builds the 24-bit frame and shifts it out on a four-wire SPI link. Chip select is active low and frames the transfer.

Most operations send one frame. Two operations send two:

- **Global offset write.** Sends two special frames back to back: the first loads offset DAC 0, the second loads offset DAC 1.
- **Readback.** Sends a request frame. Chip select then stays high for a minimum time. A zero frame follows at a slower clock, and the register contents return on MISO during it.

Busy tells the host when the next command may be issued. Readback results arrive with a one-cycle valid strobe.

Top module: `dac_cmd_spi`

## Requirements
- R1: Every frame is 24 bits, most significant bit first, with `spi_cs_n` low for the whole frame. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only on rising `spi_sclk`, and the DAC samples it on falling `spi_sclk`.
- R2: Operation codes 0, 1 and 2 each send one frame. Bits [23:22] are 3 for code 0 (data), 2 for code 1 (offset) and 1 for code 2 (gain). Bits [21:16] are the channel plus 8, modulo 64. Bits [15:0] are `cmd_value`.
- R3: Operation code 3 sends two frames, each with bits [23:22] = 0 and bits [15:14] = 0. The first has bits [21:16] = 2 and the second has bits [21:16] = 3. Both carry `cmd_value[13:0]` in bits [13:0].
- R4: Operation codes 8 to 14 are readbacks. The first frame has bits [23:16] = 0x05, a 9-bit address in bits [15:7] and zeros in bits [6:0]. For codes 8, 9, 10 and 11 the address is 0x000, 0x040, 0x080 or 0x0C0 respectively, plus (channel + 8). Codes 12, 13 and 14 use the fixed addresses 0x101, 0x102 and 0x103. The second frame is all zeros.
- R5: During the second readback frame, `spi_miso` is sampled on each falling `spi_sclk`. The last 16 samples appear on `rd_data`, oldest in bit 15. `rd_valid` pulses for one cycle once that frame ends. `rd_valid` never pulses for write operations.
- R6: The SCLK period is `DIV_WR` clock cycles (default 4) for every frame except the second readback frame. That frame uses `DIV_RD` cycles (default 8).
- R7: Between the two readback frames, `spi_cs_n` stays high for at least the larger of `RD_GAP` (default 14 cycles, 280 ns at 50 MHz) and `DIV_RD`. Between the two global-offset frames it stays high for at least `DIV_WR` cycles.
- R8: `busy` is high from the cycle after a command is accepted until the last frame has ended and `spi_cs_n` has been high for one SCLK period of that frame. `cmd_valid` is ignored while `busy` is high.
- R9: Operation codes 4 to 7 and 15 are ignored: no frame is sent and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 4 | Operation code |
| cmd_chan | input | 6 | DAC channel number |
| cmd_value | input | 16 | Register value for writes |
| busy | output | 1 | Command in progress |
| rd_valid | output | 1 | One-cycle strobe for readback result |
| rd_data | output | 16 | Readback result |
| spi_cs_n | output | 1 | Frame chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to DAC |
| spi_miso | input | 1 | Serial data from DAC |

## Verification
The bench sweeps every channel from 0 to 39 through the three channel-write codes and the four banked readbacks. Any slip in the channel-plus-8 field or in a bank base would show up as a wrong address or a wrong frame word. A bus model replies to each readback request with a word derived from the address it decoded. An off-by-one in the sampling edge, or a capture from the wrong frame, therefore returns a visibly shifted value.

The bench measures each SCLK period and each chip-select-high gap in cycles. A design that kept the write divider for the read data frame, or that shortened the inter-frame gap, is reported. Global-offset values above 14 bits, commands issued while busy, and unused operation codes would show up as extra, missing or unmasked frames.

// File: rtl/dac_cmd_spi.sv
module dac_cmd_spi #(
  parameter int DIV_WR = 4,
  parameter int DIV_RD = 8,
  parameter int RD_GAP = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [3:0]  cmd_op,
  input  logic [5:0]  cmd_chan,
  input  logic [15:0] cmd_value,
  output logic        busy,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        spi_cs_n,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int RD_GAP_CYC = (RD_GAP > DIV_RD) ? RD_GAP : DIV_RD;
  localparam int CW = $clog2(RD_GAP_CYC + DIV_RD + DIV_WR + 1);
  localparam logic [CW-1:0] HW = CW'(DIV_WR / 2 - 1);
  localparam logic [CW-1:0] HR = CW'(DIV_RD / 2 - 1);
  localparam logic [5:0] LAST_HALF = 6'd48;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_t;
  st_t st;

  logic [5:0]    chan_f;
  logic [8:0]    rd_addr;
  logic [23:0]   frame_a, frame_b;
  logic          op_ok, two;
  logic [23:0]   sr, sr_b;
  logic          pend, rd_op;
  logic [CW-1:0] half_lim, cyc, gap_cnt, gap_lim;
  logic [5:0]    h;
  logic [15:0]   rx;

  assign chan_f = cmd_chan + 6'd8;
  assign op_ok  = (cmd_op <= 4'd3) || (cmd_op >= 4'd8 && cmd_op <= 4'd14);
  assign two    = (cmd_op == 4'd3) || cmd_op[3];
  assign busy   = (st != S_IDLE);

  always_comb begin
    case (cmd_op)
      4'd8:    rd_addr = {3'b000, chan_f};
      4'd9:    rd_addr = {3'b001, chan_f};
      4'd10:   rd_addr = {3'b010, chan_f};
      4'd11:   rd_addr = {3'b011, chan_f};
      4'd12:   rd_addr = 9'h101;
      4'd13:   rd_addr = 9'h102;
      4'd14:   rd_addr = 9'h103;
      default: rd_addr = 9'h000;
    endcase
  end

  always_comb begin
    frame_b = 24'h0;
    case (cmd_op)
      4'd0:    frame_a = {2'b11, chan_f, cmd_value};
      4'd1:    frame_a = {2'b10, chan_f, cmd_value};
      4'd2:    frame_a = {2'b01, chan_f, cmd_value};
      4'd3: begin
        frame_a = {2'b00, 6'd2, 2'b00, cmd_value[13:0]};
        frame_b = {2'b00, 6'd3, 2'b00, cmd_value[13:0]};
      end
      default: frame_a = {2'b00, 6'd5, rd_addr, 7'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      spi_cs_n <= 1'b1;
      spi_sclk <= 1'b0;
      spi_mosi <= 1'b0;
      sr       <= '0;
      sr_b     <= '0;
      pend     <= 1'b0;
      rd_op    <= 1'b0;
      half_lim <= '0;
      cyc      <= '0;
      h        <= '0;
      gap_cnt  <= '0;
      gap_lim  <= '0;
      rx       <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid && op_ok) begin
          sr       <= frame_a;
          sr_b     <= frame_b;
          pend     <= two;
          rd_op    <= cmd_op[3];
          half_lim <= HW;
          cyc      <= '0;
          h        <= '0;
          spi_cs_n <= 1'b0;
          st       <= S_RUN;
        end
        S_RUN: if (cyc == half_lim) begin
          cyc <= '0;
          if (h == LAST_HALF) begin
            spi_cs_n <= 1'b1;
            spi_mosi <= 1'b0;
            gap_cnt  <= '0;
            gap_lim  <= pend ? (rd_op ? CW'(RD_GAP_CYC - 1) : CW'(DIV_WR - 1))
                             : (rd_op ? CW'(DIV_RD - 1) : CW'(DIV_WR - 1));
            st       <= S_GAP;
            if (rd_op && !pend) begin
              rd_valid <= 1'b1;
              rd_data  <= rx;
            end
          end else begin
            h <= h + 6'd1;
            if (!h[0]) begin
              spi_sclk <= 1'b1;
              spi_mosi <= sr[23];
              sr       <= {sr[22:0], 1'b0};
            end else begin
              spi_sclk <= 1'b0;
              rx       <= {rx[14:0], spi_miso};
            end
          end
        end else begin
          cyc <= cyc + 1'b1;
        end
        S_GAP: if (gap_cnt == gap_lim) begin
          if (pend) begin
            pend     <= 1'b0;
            sr       <= sr_b;
            half_lim <= rd_op ? HR : HW;
            cyc      <= '0;
            h        <= '0;
            spi_cs_n <= 1'b0;
            st       <= S_RUN;
          end else begin
            st <= S_IDLE;
          end
        end else begin
          gap_cnt <= gap_cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R1
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && $fell(spi_sclk)) |-> $stable(spi_mosi));

  // R5
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && op_ok) |=> busy);

  // R8
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);

  // R9
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid && !op_ok) |=> !busy);

endmodule

// File: tb/dac_cmd_spi_tb_top.sv
module dac_cmd_spi_tb_top;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [3:0] cmd_op = 0;
  logic [5:0] cmd_chan = 0;
  logic [15:0] cmd_value = 0;
  logic busy, rd_valid, spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 0;
  logic [15:0] rd_data;

  dac_cmd_spi dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_chan(cmd_chan), .cmd_value(cmd_value), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  always #10ns clk = ~clk;

  int n_chk = 0, n_err = 0, cyc = 0;
  int nfr = 0, cur_bits = 0, rb = 0, pmin = 0, pmax = 0, last_r = -1, t_csrise = 0;
  int rdv_cnt = 0;
  bit mon_en = 0;
  logic [23:0] sh = 0, reply = 0;
  logic [15:0] rd_cap = 0;
  logic [23:0] fr [0:3];
  int fbits [0:3], fminp [0:3], fmaxp [0:3], fgap [0:3];

  function automatic int rfun(int addr);
    return ((addr << 7) | 'h2A) ^ 'hBEEF;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) cyc++;
  always @(negedge clk) if (rd_valid) begin rdv_cnt++; rd_cap = rd_data; end

  always @(negedge spi_cs_n) if (mon_en) begin
    cur_bits = 0; rb = 0; pmin = 1000; pmax = 0; last_r = -1;
    if (nfr > 0 && nfr < 4) fgap[nfr] = cyc - t_csrise;
  end
  always @(negedge spi_sclk) if (mon_en && spi_cs_n === 1'b0) begin
    sh = {sh[22:0], spi_mosi}; cur_bits++;
  end
  always @(posedge spi_sclk) if (mon_en && spi_cs_n === 1'b0) begin
    if (last_r >= 0) begin
      if (cyc - last_r < pmin) pmin = cyc - last_r;
      if (cyc - last_r > pmax) pmax = cyc - last_r;
    end
    last_r = cyc;
    spi_miso <= (rb < 24) ? reply[23 - rb] : 1'b0;
    rb++;
  end
  always @(posedge spi_cs_n) if (mon_en) begin
    if (nfr < 4) begin fr[nfr] = sh; fbits[nfr] = cur_bits; fminp[nfr] = pmin; fmaxp[nfr] = pmax; end
    nfr++;
    t_csrise = cyc;
    reply = (sh[23:16] == 8'h05) ? 24'(rfun(int'(sh[15:7]))) & 24'hFFFF : 24'h0;
  end

  function automatic int exp_a(int op, int ch, int v);
    if (op < 3) return ((3 - op) << 22) | (((ch + 8) % 64) << 16) | (v & 'hFFFF);
    if (op == 3) return (2 << 16) | (v & 'h3FFF);
    if (op <= 11) return (5 << 16) | (((op - 8) * 'h40 + ch + 8) << 7);
    return (5 << 16) | ((op - 12 + 'h101) << 7);
  endfunction

  task automatic run_cmd(int op, int ch, int v, bit poke);
    int two, rd, w, addr;
    two = (op == 3 || op >= 8) ? 1 : 0;
    rd = (op >= 8) ? 1 : 0;
    nfr = 0; rdv_cnt = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'(op); cmd_chan = 6'(ch); cmd_value = 16'(v);
    @(negedge clk);
    cmd_valid = 0;
    chk(busy === 1'b1, "R8 busy after accept", busy, 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_valid = 1; cmd_op = 4'd0; cmd_chan = 6'd1; cmd_value = 16'h1234;
      @(negedge clk);
      cmd_valid = 0;
    end
    w = 0;
    while (busy && w < 3000) begin @(negedge clk); w++; end
    chk(w < 3000, "R8 busy released", w, 0);
    chk((cyc - t_csrise) >= (rd ? 8 : 4), "R8 busy tail after cs high", cyc - t_csrise, rd ? 8 : 4);
    chk(nfr == 1 + two, "R1 frame count", nfr, 1 + two);
    chk(fbits[0] == 24, "R1 bits per frame", fbits[0], 24);
    chk(fr[0] == 24'(exp_a(op, ch, v)), op < 3 ? "R2 frame" : (op == 3 ? "R3 first frame" : "R4 request frame"),
        int'(fr[0]), exp_a(op, ch, v));
    chk(fminp[0] == 4 && fmaxp[0] == 4, "R6 write sclk period", fmaxp[0], 4);
    if (two && nfr == 2) begin
      chk(fbits[1] == 24, "R1 bits second frame", fbits[1], 24);
      chk(fr[1] == (op == 3 ? 24'((3 << 16) | (v & 'h3FFF)) : 24'h0),
          op == 3 ? "R3 second frame" : "R4 zero frame", int'(fr[1]), op == 3 ? ((3 << 16) | (v & 'h3FFF)) : 0);
      chk(fgap[1] >= (rd ? 14 : 4), "R7 cs high gap", fgap[1], rd ? 14 : 4);
      chk(fminp[1] == (rd ? 8 : 4) && fmaxp[1] == (rd ? 8 : 4), "R6 second frame period", fmaxp[1], rd ? 8 : 4);
    end
    chk(rdv_cnt == rd, "R5 valid strobe count", rdv_cnt, rd);
    if (rd) begin
      addr = (op <= 11) ? ((op - 8) * 'h40 + ch + 8) : (op - 12 + 'h101);
      chk(int'(rd_cap) == (rfun(addr) & 'hFFFF), "R5 readback data", rd_cap, rfun(addr) & 'hFFFF);
    end
  endtask

  task automatic bad_op(int op);
    nfr = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 4'(op);
    @(negedge clk);
    cmd_valid = 0;
    chk(busy === 1'b0, "R9 busy stays low", busy, 0);
    repeat (120) @(negedge clk);
    chk(nfr == 0 && spi_cs_n === 1'b1, "R9 no frame", nfr, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0 && busy === 1'b0 && rd_valid === 1'b0,
        "R1 reset state", {spi_cs_n, spi_sclk, busy, rd_valid}, 4'b1000);
    rst_n = 1;
    mon_en = 1;
    repeat (2) @(negedge clk);
    for (int ch = 0; ch < 40; ch++)
      for (int op = 0; op < 3; op++)
        run_cmd(op, ch, ch == 0 ? 0 : (ch == 39 ? 'hFFFF : ((ch * 'h0531 + op * 'h1111) ^ 'hA5A5) & 'hFFFF), 0);
    run_cmd(3, 0, 'h0000, 0);
    run_cmd(3, 0, 'h3FFF, 0);
    run_cmd(3, 0, 'hFFFF, 0);
    run_cmd(3, 0, 'h2000, 0);
    for (int op = 8; op < 12; op++)
      for (int ch = 0; ch < 40; ch++)
        run_cmd(op, ch, 0, 0);
    for (int op = 12; op < 15; op++) run_cmd(op, 0, 0, 0);
    run_cmd(9, 5, 0, 1);
    run_cmd(3, 0, 'h1555, 1);
    bad_op(4); bad_op(5); bad_op(6); bad_op(7); bad_op(15);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule